// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block turns the outcome of one ALU operation into the six arithmetic status flags and keeps them, together with three control flags, in a 16-bit flag word. Each cycle it is given the two operands, the result, the raw adder carry-out, a byte/word width select and an operation class: add, subtract or logic. When the update enable is high, the arithmetic flags derived from those inputs are captured at the next rising clock edge. When it is low, they keep their values.

The three control flags are direction, interrupt enable and trap. Each has its own write strobe and value input, and arithmetic updates never touch them. The flag word is a registered output with fixed bit positions, so any consumer can decode it directly.

Top module: `arith_flag_word`

## Requirements
- R1: After the asynchronous active-low reset, every bit of the flag word reads 0.
- R2: The carry flag (bit 0) is captured as the adder carry-out for add. For subtract it is the inverted carry-out, i.e. the borrow, set when the first operand is unsigned-below the second. A logic operation clears it.
- R3: The auxiliary flag (bit 4) is set on a carry out of bit 3 for add, or on a borrow into bit 3 for subtract, meaning low nibble of A below low nibble of B. A logic operation clears it.
- R4: The zero flag (bit 6) is set when the result, taken at the selected width, is all zeros.
- R5: The parity flag (bit 2) is 1 when result bits 7..0 hold an even number of ones, and 0 when odd, in both byte and word mode.
- R6: The sign flag (bit 7) equals the result's top bit at the selected width: bit 7 for byte, bit 15 for word.
- R7: The overflow flag (bit 11) is set when the signed result leaves the range of the selected width. It is computed as the carry into the top bit XOR the carry out of it. A logic operation clears it.
- R8: Trap sits at bit 8, interrupt enable at bit 9 and direction at bit 10. Bits 1, 3, 5, 12, 13, 14 and 15 always read 0.
- R9: With the update enable low, the six arithmetic flags keep their previous values whatever the other inputs do.
- R10: Each control flag takes its value input on the edge where its own strobe is high and otherwise holds. An arithmetic update in the same cycle neither blocks nor alters it.
- R11: In byte mode, bits 15..8 of the operands and of the result have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand (subtrahend for subtract) |
| result | input | 16 | ALU result |
| carryOut | input | 1 | Raw adder carry out of the top bit at the selected width |
| wordOp | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| subOp | input | 1 | 1 when the operation is a subtract |
| logicOp | input | 1 | 1 when the operation is a logic operation |
| updateEn | input | 1 | Capture the arithmetic flags this cycle |
| dirWrEn | input | 1 | Write strobe for the direction flag |
| dirVal | input | 1 | Value for the direction flag |
| intWrEn | input | 1 | Write strobe for the interrupt-enable flag |
| intVal | input | 1 | Value for the interrupt-enable flag |
| trapWrEn | input | 1 | Write strobe for the trap flag |
| trapVal | input | 1 | Value for the trap flag |
| flagWord | output | 16 | Registered flag word |

## Verification
The two functions that can meet in one cycle are an arithmetic flag capture and a control flag write. The bench provokes this by raising the update enable together with one or more control-flag strobes. It then checks that the new arithmetic flags and the written control bit both appear in the next flag word, and that the control flags not written keep their value. It also checks the reverse case: a later arithmetic-only update, with different operands, leaves all three control bits exactly as last written.

// File: rtl/flag_word_pkg.sv
package flag_word_pkg;
  localparam int FLAG_W = 16;
  localparam int NIB_W  = 4;

  // Fixed positions in the flag word; consumers decode these directly.
  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  typedef struct packed {
    logic loadArith;
    logic wordMode;
    logic subMode;
    logic logicMode;
    logic loadDir;
    logic dirVal;
    logic loadInt;
    logic intVal;
    logic loadTrap;
    logic trapVal;
  } flag_strobe_t;
endpackage

// File: rtl/flag_control.sv
module flag_control
  import flag_word_pkg::*;
(
  input  logic         updateEn,
  input  logic         wordOp,
  input  logic         subOp,
  input  logic         logicOp,
  input  logic         dirWrEn,
  input  logic         dirVal,
  input  logic         intWrEn,
  input  logic         intVal,
  input  logic         trapWrEn,
  input  logic         trapVal,
  output flag_strobe_t strobe
);
  always_comb begin
    strobe           = '0;
    strobe.loadArith = updateEn;
    strobe.wordMode  = wordOp;
    // A logic operation takes precedence over the subtract select.
    strobe.logicMode = logicOp;
    strobe.subMode   = subOp & ~logicOp;
    strobe.loadDir   = dirWrEn;
    strobe.dirVal    = dirVal;
    strobe.loadInt   = intWrEn;
    strobe.intVal    = intVal;
    strobe.loadTrap  = trapWrEn;
    strobe.trapVal   = trapVal;
  end
endmodule

// File: rtl/flag_datapath.sv
module flag_datapath
  import flag_word_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flag_strobe_t      strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  output logic [FLAG_W-1:0] flagWord
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] carryVec;
  logic [IDX_W-1:0]  msbIdx;
  logic              carryIntoMsb;
  logic              borrowOrCarry;
  logic              zeroNow;
  logic              cfNext, pfNext, afNext, zfNext, sfNext, ofNext;
  logic              cfQ, pfQ, afQ, zfQ, sfQ, ofQ;
  logic              tfQ, ifQ, dfQ;

  // a ^ b ^ r recovers the carry (add) or borrow (subtract) into each bit.
  always_comb begin
    carryVec      = opA ^ opB ^ result;
    msbIdx        = strobe.wordMode ? IDX_W'(DATA_W - 1) : IDX_W'(BYTE_W - 1);
    carryIntoMsb  = carryVec[msbIdx];
    borrowOrCarry = strobe.subMode ? ~carryOut : carryOut;
    zeroNow       = strobe.wordMode ? (result == '0) : (result[BYTE_W-1:0] == '0);

    cfNext = strobe.logicMode ? 1'b0 : borrowOrCarry;
    afNext = strobe.logicMode ? 1'b0 : carryVec[NIB_W];
    ofNext = strobe.logicMode ? 1'b0 : (carryIntoMsb ^ borrowOrCarry);
    zfNext = zeroNow;
    sfNext = result[msbIdx];
    pfNext = ~(^result[BYTE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfQ <= 1'b0; pfQ <= 1'b0; afQ <= 1'b0;
      zfQ <= 1'b0; sfQ <= 1'b0; ofQ <= 1'b0;
    end else if (strobe.loadArith) begin
      cfQ <= cfNext; pfQ <= pfNext; afQ <= afNext;
      zfQ <= zfNext; sfQ <= sfNext; ofQ <= ofNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tfQ <= 1'b0; ifQ <= 1'b0; dfQ <= 1'b0;
    end else begin
      if (strobe.loadTrap) tfQ <= strobe.trapVal;
      if (strobe.loadInt)  ifQ <= strobe.intVal;
      if (strobe.loadDir)  dfQ <= strobe.dirVal;
    end
  end

  always_comb begin
    flagWord         = '0;
    flagWord[CF_POS] = cfQ;
    flagWord[PF_POS] = pfQ;
    flagWord[AF_POS] = afQ;
    flagWord[ZF_POS] = zfQ;
    flagWord[SF_POS] = sfQ;
    flagWord[TF_POS] = tfQ;
    flagWord[IF_POS] = ifQ;
    flagWord[DF_POS] = dfQ;
    flagWord[OF_POS] = ofQ;
  end
endmodule

// File: rtl/arith_flag_word.sv
module arith_flag_word
  import flag_word_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic              wordOp,
  input  logic              subOp,
  input  logic              logicOp,
  input  logic              updateEn,
  input  logic              dirWrEn,
  input  logic              dirVal,
  input  logic              intWrEn,
  input  logic              intVal,
  input  logic              trapWrEn,
  input  logic              trapVal,
  output logic [FLAG_W-1:0] flagWord
);
  flag_strobe_t strobe;

  flag_control u_ctrl (
    .updateEn (updateEn),
    .wordOp   (wordOp),
    .subOp    (subOp),
    .logicOp  (logicOp),
    .dirWrEn  (dirWrEn),
    .dirVal   (dirVal),
    .intWrEn  (intWrEn),
    .intVal   (intVal),
    .trapWrEn (trapWrEn),
    .trapVal  (trapVal),
    .strobe   (strobe)
  );

  flag_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryOut (carryOut),
    .flagWord (flagWord)
  );
endmodule

// File: rtl/flag_word_chk.sv
module flag_word_chk
  import flag_word_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [15:0] result,
  input logic        wordOp,
  input logic        logicOp,
  input logic        updateEn,
  input logic        dirWrEn,
  input logic        dirVal,
  input logic        intWrEn,
  input logic        trapWrEn,
  input logic [15:0] flagWord
);
  localparam logic [15:0] UNUSED_MASK = 16'hF02A;

  // R9
  hold_arith_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateEn |=> $stable({flagWord[OF_POS], flagWord[SF_POS], flagWord[ZF_POS],
                           flagWord[AF_POS], flagWord[PF_POS], flagWord[CF_POS]}));
  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dirWrEn |=> $stable(flagWord[DF_POS]));
  // R10
  int_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intWrEn |=> $stable(flagWord[IF_POS]));
  // R10
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trapWrEn |=> $stable(flagWord[TF_POS]));
  // R10
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirWrEn |=> flagWord[DF_POS] == $past(dirVal));
  // R2
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateEn && logicOp |=> !flagWord[CF_POS] && !flagWord[OF_POS] && !flagWord[AF_POS]);
  // R4
  zero_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateEn && wordOp && result == 16'h0000 |=> flagWord[ZF_POS]);
  // R5
  parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateEn |=> flagWord[PF_POS] == ($countones($past(result[7:0])) % 2 == 0));
  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagWord & UNUSED_MASK) == 16'h0000);
endmodule

bind arith_flag_word flag_word_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .result   (result),
  .wordOp   (wordOp),
  .logicOp  (logicOp),
  .updateEn (updateEn),
  .dirWrEn  (dirWrEn),
  .dirVal   (dirVal),
  .intWrEn  (intWrEn),
  .trapWrEn (trapWrEn),
  .flagWord (flagWord)
);

// File: tb/arith_flag_word_tb.sv
module arith_flag_word_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0, opB = '0, result = '0;
  logic        carryOut = 1'b0, wordOp = 1'b0, subOp = 1'b0, logicOp = 1'b0;
  logic        updateEn = 1'b0;
  logic        dirWrEn = 1'b0, dirVal = 1'b0, intWrEn = 1'b0, intVal = 1'b0;
  logic        trapWrEn = 1'b0, trapVal = 1'b0;
  logic [15:0] flagWord;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit expTf = 0, expIf = 0, expDf = 0;
  bit arithCf = 0, arithPf = 0, arithAf = 0, arithZf = 0, arithSf = 0, arithOf = 0;

  always #5 clk = ~clk;

  arith_flag_word u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .result(result),
    .carryOut(carryOut), .wordOp(wordOp), .subOp(subOp), .logicOp(logicOp),
    .updateEn(updateEn), .dirWrEn(dirWrEn), .dirVal(dirVal),
    .intWrEn(intWrEn), .intVal(intVal), .trapWrEn(trapWrEn), .trapVal(trapVal),
    .flagWord(flagWord)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord();
    logic [15:0] w = '0;
    w[0] = arithCf; w[2] = arithPf; w[4] = arithAf; w[6] = arithZf;
    w[7] = arithSf; w[8] = expTf; w[9] = expIf; w[10] = expDf; w[11] = arithOf;
    return w;
  endfunction

  task automatic checkAll();
    chk("R2 carry", int'(flagWord[0]), int'(arithCf));
    chk("R3 aux", int'(flagWord[4]), int'(arithAf));
    chk("R4 zero", int'(flagWord[6]), int'(arithZf));
    chk("R5 parity", int'(flagWord[2]), int'(arithPf));
    chk("R6 sign", int'(flagWord[7]), int'(arithSf));
    chk("R7 overflow", int'(flagWord[11]), int'(arithOf));
    chk("R8 layout", int'(flagWord), int'(expWord()));
  endtask

  // Drives one add/subtract and checks the captured flags one edge later.
  task automatic runArith(input logic [15:0] a, input logic [15:0] b,
                          input bit word, input bit sub);
    int w = word ? 16 : 8;
    int mask = word ? 32'hFFFF : 32'hFF;
    int ua = int'(a) & mask;
    int ub = int'(b) & mask;
    int sa = (ua >= (1 << (w - 1))) ? ua - (1 << w) : ua;
    int sb = (ub >= (1 << (w - 1))) ? ub - (1 << w) : ub;
    int full = sub ? ua - ub : ua + ub;
    int sres = sub ? sa - sb : sa + sb;
    int r = full & mask;
    @(negedge clk);
    opA = a; opB = b; wordOp = word; subOp = sub; logicOp = 1'b0;
    // R11: junk in the upper byte of the result during byte mode
    result = word ? 16'(r) : {8'h5A ^ a[15:8], 8'(r)};
    carryOut = sub ? (ua >= ub) : (full > mask);
    updateEn = 1'b1;
    arithCf = sub ? (ua < ub) : (full > mask);
    arithAf = sub ? ((ua & 15) < (ub & 15)) : (((ua & 15) + (ub & 15)) > 15);
    arithOf = (sres > (1 << (w - 1)) - 1) || (sres < -(1 << (w - 1)));
    arithZf = (r == 0);
    arithSf = ((r >> (w - 1)) & 1) == 1;
    arithPf = ($countones(r & 255) % 2) == 0;
    @(negedge clk);
    updateEn = 1'b0;
    checkAll();
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset", int'(flagWord), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(flagWord), 0);

    // R2 R3 R4 R5 R6 R7 R11: byte sweep with junk upper bytes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a += 7)
        for (int b = 0; b < 256; b += 3)
          runArith({8'(a * 13 + 1), 8'(a)}, {8'(b * 29 + 3), 8'(b)}, 1'b0, s[0]);
    runArith(16'hFF7F, 16'h0001, 1'b0, 1'b0);
    runArith(16'h1280, 16'h3401, 1'b0, 1'b1);
    runArith(16'hAB00, 16'h0000, 1'b0, 1'b1);

    // Word sweep plus corners
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 1500; i++)
        runArith(16'(i * 40503 + 7), 16'(i * 9973 + 12345), 1'b1, s[0]);
    runArith(16'h7FFF, 16'h0001, 1'b1, 1'b0);
    runArith(16'h8000, 16'h0001, 1'b1, 1'b1);
    runArith(16'hFFFF, 16'h0001, 1'b1, 1'b0);
    runArith(16'h0000, 16'h0000, 1'b1, 1'b1);
    runArith(16'h00FF, 16'h0001, 1'b1, 1'b0);

    // Logic operations clear CF, AF, OF (R2 R3 R7)
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a = 16'(i * 7919 + 5);
      logic [15:0] b = 16'(i * 104729 + 17);
      logic [15:0] r = a ^ b;
      @(negedge clk);
      opA = a; opB = b; result = r; carryOut = 1'b1;
      wordOp = i[0]; subOp = i[1]; logicOp = 1'b1; updateEn = 1'b1;
      arithCf = 0; arithAf = 0; arithOf = 0;
      arithZf = i[0] ? (r == 0) : (r[7:0] == 0);
      arithSf = i[0] ? r[15] : r[7];
      arithPf = ($countones(r[7:0]) % 2) == 0;
      @(negedge clk);
      updateEn = 1'b0; logicOp = 1'b0;
      checkAll();
    end

    // R9: update disabled, inputs churn, arithmetic flags stay
    runArith(16'h0080, 16'h0080, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      opA = 16'(i * 321); opB = 16'(i * 77); result = 16'(i * 5);
      carryOut = i[0]; wordOp = i[1]; subOp = i[2]; logicOp = i[3];
      @(negedge clk);
      chk("R9 hold", int'(flagWord), int'(expWord()));
    end
    logicOp = 1'b0;

    // R10: control writes alone, then combined with arithmetic update
    @(negedge clk);
    dirWrEn = 1'b1; dirVal = 1'b1; expDf = 1;
    @(negedge clk);
    dirWrEn = 1'b0;
    chk("R10 dir write", int'(flagWord), int'(expWord()));
    @(negedge clk);
    intWrEn = 1'b1; intVal = 1'b1; trapWrEn = 1'b1; trapVal = 1'b1;
    expIf = 1; expTf = 1;
    opA = 16'h7FFF; opB = 16'h0001; result = 16'h8000; carryOut = 1'b0;
    wordOp = 1'b1; subOp = 1'b0; logicOp = 1'b0; updateEn = 1'b1;
    arithCf = 0; arithAf = 1; arithOf = 1; arithZf = 0; arithSf = 1; arithPf = 1;
    @(negedge clk);
    intWrEn = 1'b0; trapWrEn = 1'b0; updateEn = 1'b0;
    chk("R10 same cycle ctrl+arith", int'(flagWord), int'(expWord()));
    // Arithmetic-only updates leave control bits unchanged
    runArith(16'h0000, 16'h0000, 1'b1, 1'b1);
    chk("R10 ctrl kept", int'(flagWord[10:8]), 7);
    @(negedge clk);
    dirWrEn = 1'b1; dirVal = 1'b0; trapWrEn = 1'b1; trapVal = 1'b0;
    expDf = 0; expTf = 0;
    @(negedge clk);
    dirWrEn = 1'b0; trapWrEn = 1'b0;
    chk("R10 clear", int'(flagWord), int'(expWord()));
    runArith(16'h00F0, 16'h0011, 1'b0, 1'b1);
    chk("R10 int kept", int'(flagWord[9]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule